// File: doc/BRIEF.md
# Oversampled Serial Receiver with Status Queue

The block turns an asynchronous serial line into bytes. Each character has one start bit, eight data bits sent least significant bit first, and one stop bit. The block oversamples the line, checks every frame and records each character together with two status flags. Records are held in a queue of up to 16 entries when queue mode is on. With queue mode off, which is the state after any reset, only a single holding slot is used.

Records leave through one valid/ready read stream. This stream is the same in both modes. While `rd_valid` is high, the head record is shown on `rd_data`, `rd_fe` and `rd_brk`. It is removed on a clock edge where `rd_valid` and `rd_ready` are both high. While the consumer holds `rd_ready` low, the record stays put and unchanged. `rd_ready` has no effect while `rd_valid` is low. The receiver is never stalled by the consumer: a character that finds the storage full is dropped and a sticky overflow flag is raised instead.

One interrupt line reports all receive events. Two enables gate it:
- Ready enable: gates the fill-level and break causes.
- Error enable: gates the framing-error and overflow causes.

Top module: `serial_rx_queue`

## Requirements
- R1: Sample timing and frame format.
  - The line is sampled once every `baud_div`+1 clock cycles, which gives 8 samples per bit.
  - Each bit's value is the majority of its samples 3, 4 and 5, counting from 0.
  - Data bits are assembled least significant bit first into `rd_data`.
- R2: Start-bit check.
  - A falling edge starts a frame only if the start bit's majority vote is low.
  - Otherwise the receiver returns to idle and stores nothing.
- R3: Framing error.
  - A record whose stop bit votes low carries `rd_fe`=1.
  - After such a frame, the receiver waits for the line to go high before it accepts a new start.
- R4: Break flag.
  - `rd_brk`=1 exactly when the data byte is zero and the stop bit votes low.
  - Such a record therefore also carries `rd_fe`=1.
- R5: Queue mode holds up to 16 records and delivers them in arrival order.
- R6: Single-slot mode.
  - With queue mode off, at most one record is held.
  - This mode is the reset state.
- R7: Overflow.
  - A character that completes while the storage is full is discarded, and the stored records are kept.
  - `ovf_flag` is set and stays set until a one-cycle `ovf_clr` pulse clears it.
- R8: Read stream.
  - A record is removed on each edge with `rd_valid` and `rd_ready` both high.
  - While `rd_ready` is low, the outputs `rd_data`, `rd_fe` and `rd_brk` stay stable.
- R9: Fill-level interrupt.
  - With the ready enable on, `irq` is high while the record count is at least the threshold.
  - In queue mode the threshold is `cfg_thresh`+1 (1 to 16). In single-slot mode it is 1.
- R10: With the ready enable on, `irq` is high while the head record has `rd_brk`=1.
- R11: With the error enable on, `irq` is high while the head record has `rd_fe`=1 or `ovf_flag` is set.
- R12: Soft reset and mode change.
  - A `soft_rst` pulse turns queue mode and both enables off, empties the storage and clears `ovf_flag`.
  - A `cfg_we` write that changes the queue-mode bit empties the storage.
- R13: After `rst_n`, `rd_valid`, `ovf_flag` and `irq` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| soft_rst | input | 1 | Synchronous soft reset pulse |
| baud_div | input | 16 | Clock cycles per line sample, minus one |
| cfg_we | input | 1 | Loads the four configuration fields below |
| cfg_fifo_en | input | 1 | Queue mode (1) or single-slot mode (0) |
| cfg_rdy_ie | input | 1 | Ready enable: fill-level and break causes |
| cfg_err_ie | input | 1 | Error enable: framing and overflow causes |
| cfg_thresh | input | 4 | Fill threshold minus one |
| ovf_clr | input | 1 | Clears the overflow flag |
| rxd | input | 1 | Serial line, idle high |
| rd_valid | output | 1 | A record is available |
| rd_ready | input | 1 | Consumer accepts the head record |
| rd_data | output | 8 | Head record data byte |
| rd_fe | output | 1 | Head record framing error |
| rd_brk | output | 1 | Head record break |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Receive interrupt |

## Verification
The bench fills the queue to exactly 16 records and then sends one character more. A design with an off-by-one full test would either lose the sixteenth record or overwrite the head. The bench sends a second character into the occupied single slot and reads back the first. It also checks that a soft reset falls back to that one-slot limit. A design that ignored the mode would keep both characters, and a design that overwrote the slot would show the newer byte.

A short low glitch must leave nothing behind. A zero byte with a low stop bit must raise both flags and then let a normal frame follow. Without the wait for a high line, a break would repeat as a run of false records. Each interrupt cause is toggled with its own enable while the other enable is off, so a cause wired to the wrong enable shows up as a wrong `irq` level.

// File: rtl/srq_pkg.sv
package srq_pkg;

  // One stored character: data byte plus its two status flags.
  typedef struct packed {
    logic       brk;
    logic       fe;
    logic [7:0] data;
  } rx_entry_t;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP,
    RX_HOLD
  } rx_state_e;

endpackage

// File: rtl/srq_baud_tick.sv
module srq_baud_tick #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);

  logic [DIV_W-1:0] cnt_q;

  assign tick = run && (cnt_q == div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run || tick) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/srq_rx_frame.sv
module srq_rx_frame
  import srq_pkg::*;
#(
  parameter int OSR   = 8,
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             rxd,
  input  logic [DIV_W-1:0] div,
  output logic             push,
  output rx_entry_t        ent
);

  localparam int SUB_W = $clog2(OSR);
  localparam int MID   = OSR / 2;
  localparam logic [SUB_W-1:0] VOTE_LO  = SUB_W'(MID - 1);
  localparam logic [SUB_W-1:0] VOTE_HI  = SUB_W'(MID + 1);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OSR - 1);

  logic [1:0]       sync_q;
  logic             rx_s;
  rx_state_e        state_q;
  logic [SUB_W-1:0] sub_q;
  logic [2:0]       bit_q;
  logic [1:0]       ones_q;
  logic [7:0]       shreg_q;
  logic             run;
  logic             tick;
  logic             in_win;
  logic             last_vote;
  logic             last_sub;
  logic             vote;

  assign rx_s      = sync_q[1];
  assign run       = (state_q == RX_START) || (state_q == RX_DATA) || (state_q == RX_STOP);
  assign in_win    = (sub_q >= VOTE_LO) && (sub_q <= VOTE_HI);
  assign last_vote = (sub_q == VOTE_HI);
  assign last_sub  = (sub_q == SUB_LAST);
  assign vote      = ({1'b0, ones_q} + {2'b00, rx_s}) >= 3'd2;

  srq_baud_tick #(.DIV_W(DIV_W)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (run),
    .div  (div),
    .tick (tick)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b11;
    end else begin
      sync_q <= {sync_q[0], rxd};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      sub_q   <= '0;
      bit_q   <= '0;
      ones_q  <= '0;
      shreg_q <= '0;
      push    <= 1'b0;
      ent     <= '0;
    end else if (clr) begin
      state_q <= RX_IDLE;
      sub_q   <= '0;
      bit_q   <= '0;
      ones_q  <= '0;
      push    <= 1'b0;
    end else begin
      push <= 1'b0;
      case (state_q)
        RX_IDLE: begin
          if (!rx_s) begin
            state_q <= RX_START;
            sub_q   <= '0;
            ones_q  <= '0;
          end
        end
        RX_HOLD: begin
          if (rx_s) state_q <= RX_IDLE;
        end
        default: begin
          if (tick) begin
            sub_q <= last_sub ? '0 : sub_q + 1'b1;
            if (last_vote) begin
              ones_q <= '0;
            end else if (in_win) begin
              ones_q <= ones_q + {1'b0, rx_s};
            end
            case (state_q)
              RX_START: begin
                if (last_vote && vote) begin
                  state_q <= RX_IDLE;
                end else if (last_sub) begin
                  state_q <= RX_DATA;
                  bit_q   <= '0;
                end
              end
              RX_DATA: begin
                if (last_vote) shreg_q <= {vote, shreg_q[7:1]};
                if (last_sub) begin
                  if (bit_q == 3'd7) state_q <= RX_STOP;
                  bit_q <= bit_q + 1'b1;
                end
              end
              RX_STOP: begin
                if (last_vote) begin
                  push     <= 1'b1;
                  ent.data <= shreg_q;
                  ent.fe   <= !vote;
                  ent.brk  <= !vote && (shreg_q == 8'h00);
                  state_q  <= vote ? RX_IDLE : RX_HOLD;
                end
              end
              default: ;
            endcase
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/srq_store.sv
module srq_store
  import srq_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         flush,
  input  logic                         fifo_mode,
  input  logic                         push,
  input  rx_entry_t                    wr_ent,
  input  logic                         pop,
  output rx_entry_t                    rd_ent,
  output logic [$clog2(DEPTH+1)-1:0]   level,
  output logic                         drop
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

  rx_entry_t        mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q;
  logic [PTR_W-1:0] rd_ptr_q;
  logic [CNT_W-1:0] cap;
  logic             accept;
  logic             take;

  assign cap    = fifo_mode ? CNT_W'(DEPTH) : CNT_W'(1);
  assign accept = push && (level < cap);
  assign drop   = push && !accept && !flush;
  assign take   = pop && (level != '0);
  assign rd_ent = mem[rd_ptr_q];

  always_ff @(posedge clk) begin
    if (accept && !flush) mem[wr_ptr_q] <= wr_ent;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      level    <= '0;
    end else if (flush) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      level    <= '0;
    end else begin
      if (accept) wr_ptr_q <= (wr_ptr_q == PTR_LAST) ? '0 : wr_ptr_q + 1'b1;
      if (take)   rd_ptr_q <= (rd_ptr_q == PTR_LAST) ? '0 : rd_ptr_q + 1'b1;
      case ({accept, take})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

endmodule

// File: rtl/srq_irq.sv
module srq_irq #(
  parameter int CNT_W = 5
) (
  input  logic [CNT_W-1:0] level,
  input  logic [CNT_W-1:0] thr,
  input  logic             head_valid,
  input  logic             head_fe,
  input  logic             head_brk,
  input  logic             ovf,
  input  logic             rdy_ie,
  input  logic             err_ie,
  output logic             irq
);

  logic rdy_cause;
  logic err_cause;

  assign rdy_cause = (level >= thr) || (head_valid && head_brk);
  assign err_cause = (head_valid && head_fe) || ovf;
  assign irq       = (rdy_ie && rdy_cause) || (err_ie && err_cause);

endmodule

// File: rtl/serial_rx_queue.sv
module serial_rx_queue
  import srq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int OSR   = 8,
  parameter int DIV_W = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         soft_rst,
  input  logic [DIV_W-1:0]             baud_div,
  input  logic                         cfg_we,
  input  logic                         cfg_fifo_en,
  input  logic                         cfg_rdy_ie,
  input  logic                         cfg_err_ie,
  input  logic [$clog2(DEPTH)-1:0]     cfg_thresh,
  input  logic                         ovf_clr,
  input  logic                         rxd,
  output logic                         rd_valid,
  input  logic                         rd_ready,
  output logic [7:0]                   rd_data,
  output logic                         rd_fe,
  output logic                         rd_brk,
  output logic                         ovf_flag,
  output logic                         irq
);

  localparam int TH_W  = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic             fifo_en_q;
  logic             rdy_ie_q;
  logic             err_ie_q;
  logic [TH_W-1:0]  thresh_q;
  logic             flush;
  logic             push;
  logic             drop;
  rx_entry_t        wr_ent;
  rx_entry_t        head;
  logic [CNT_W-1:0] level;
  logic [CNT_W-1:0] thr_eff;

  assign flush   = soft_rst || (cfg_we && (cfg_fifo_en != fifo_en_q));
  assign thr_eff = fifo_en_q ? (CNT_W'(thresh_q) + 1'b1) : CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fifo_en_q <= 1'b0;
      rdy_ie_q  <= 1'b0;
      err_ie_q  <= 1'b0;
      thresh_q  <= '0;
    end else if (soft_rst) begin
      fifo_en_q <= 1'b0;
      rdy_ie_q  <= 1'b0;
      err_ie_q  <= 1'b0;
      thresh_q  <= '0;
    end else if (cfg_we) begin
      fifo_en_q <= cfg_fifo_en;
      rdy_ie_q  <= cfg_rdy_ie;
      err_ie_q  <= cfg_err_ie;
      thresh_q  <= cfg_thresh;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_flag <= 1'b0;
    end else if (soft_rst) begin
      ovf_flag <= 1'b0;
    end else if (drop) begin
      ovf_flag <= 1'b1;
    end else if (ovf_clr) begin
      ovf_flag <= 1'b0;
    end
  end

  srq_rx_frame #(.OSR(OSR), .DIV_W(DIV_W)) u_frame (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (soft_rst),
    .rxd  (rxd),
    .div  (baud_div),
    .push (push),
    .ent  (wr_ent)
  );

  srq_store #(.DEPTH(DEPTH)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush),
    .fifo_mode(fifo_en_q),
    .push     (push),
    .wr_ent   (wr_ent),
    .pop      (rd_ready),
    .rd_ent   (head),
    .level    (level),
    .drop     (drop)
  );

  assign rd_valid = (level != '0);
  assign rd_data  = head.data;
  assign rd_fe    = head.fe;
  assign rd_brk   = head.brk;

  srq_irq #(.CNT_W(CNT_W)) u_irq (
    .level     (level),
    .thr       (thr_eff),
    .head_valid(rd_valid),
    .head_fe   (head.fe),
    .head_brk  (head.brk),
    .ovf       (ovf_flag),
    .rdy_ie    (rdy_ie_q),
    .err_ie    (err_ie_q),
    .irq       (irq)
  );

endmodule

// File: rtl/srq_checker.sv
module srq_checker #(
  parameter int DEPTH = 16
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       soft_rst,
  input logic                       cfg_we,
  input logic                       rd_valid,
  input logic                       rd_ready,
  input logic [7:0]                 rd_data,
  input logic                       rd_fe,
  input logic                       rd_brk,
  input logic                       ovf_flag,
  input logic                       ovf_clr,
  input logic                       irq,
  input logic                       fifo_en,
  input logic                       rdy_ie,
  input logic                       err_ie,
  input logic [$clog2(DEPTH+1)-1:0] level
);

  AST_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready && !soft_rst && !cfg_we |=> rd_valid && $stable({rd_data, rd_fe, rd_brk})); // R8

  AST_BRK_HAS_FE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && rd_brk |-> rd_fe && (rd_data == 8'h00)); // R4

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag && !ovf_clr && !soft_rst |=> ovf_flag); // R7

  AST_SINGLE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_en |-> level <= 1); // R6

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    level <= DEPTH); // R5

  AST_SOFT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> !fifo_en && !rd_valid && !ovf_flag && !irq); // R12

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !rdy_ie && !err_ie |-> !irq); // R9

endmodule

bind serial_rx_queue srq_checker #(.DEPTH(DEPTH)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .soft_rst(soft_rst),
  .cfg_we  (cfg_we),
  .rd_valid(rd_valid),
  .rd_ready(rd_ready),
  .rd_data (rd_data),
  .rd_fe   (rd_fe),
  .rd_brk  (rd_brk),
  .ovf_flag(ovf_flag),
  .ovf_clr (ovf_clr),
  .irq     (irq),
  .fifo_en (fifo_en_q),
  .rdy_ie  (rdy_ie_q),
  .err_ie  (err_ie_q),
  .level   (level)
);

// File: tb/serial_rx_queue_tb.sv
`timescale 1ns/100ps
module serial_rx_queue_tb;

  localparam int DIV = 3;
  localparam int BIT = 8 * (DIV + 1);

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       soft_rst = 1'b0;
  logic [15:0] baud_div = 16'(DIV);
  logic       cfg_we = 1'b0;
  logic       cfg_fifo_en = 1'b0;
  logic       cfg_rdy_ie = 1'b0;
  logic       cfg_err_ie = 1'b0;
  logic [3:0] cfg_thresh = 4'd0;
  logic       ovf_clr = 1'b0;
  logic       rxd = 1'b1;
  logic       rd_valid;
  logic       rd_ready = 1'b0;
  logic [7:0] rd_data;
  logic       rd_fe;
  logic       rd_brk;
  logic       ovf_flag;
  logic       irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit in_flight = 0;

  // Reference model
  logic [9:0] q[$];
  bit m_fifo = 0, m_rdy = 0, m_err = 0, m_ovf = 0;
  int m_thr = 0;

  always #2.5 clk = ~clk;

  serial_rx_queue u_dut (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .baud_div(baud_div),
    .cfg_we(cfg_we), .cfg_fifo_en(cfg_fifo_en), .cfg_rdy_ie(cfg_rdy_ie),
    .cfg_err_ie(cfg_err_ie), .cfg_thresh(cfg_thresh), .ovf_clr(ovf_clr),
    .rxd(rxd), .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .rd_fe(rd_fe), .rd_brk(rd_brk), .ovf_flag(ovf_flag), .irq(irq)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic bit model_irq();
    int thr;
    bit hv;
    thr = m_fifo ? m_thr + 1 : 1;
    hv = q.size() > 0;
    return (m_rdy && ((q.size() >= thr) || (hv && q[0][9]))) ||
           (m_err && ((hv && q[0][8]) || m_ovf));
  endfunction

  // Per-clock comparison against the model while no frame is on the line.
  always @(negedge clk) begin
    if (rst_n && !in_flight && !done) begin
      bit ev;
      ev = q.size() > 0;
      chk(rd_valid == ev, "R5", "rd_valid", rd_valid, ev);
      if (ev && rd_valid) begin
        chk(rd_data == q[0][7:0], "R1", "rd_data", rd_data, q[0][7:0]);
        chk(rd_fe == q[0][8], "R3", "rd_fe", rd_fe, q[0][8]);
        chk(rd_brk == q[0][9], "R4", "rd_brk", rd_brk, q[0][9]);
      end
      chk(ovf_flag == m_ovf, "R7", "ovf_flag", ovf_flag, m_ovf);
      chk(irq == model_irq(), "R9", "irq", irq, model_irq());
    end
  end

  task automatic cfg(input bit fe, input bit rie, input bit eie, input int th);
    @(negedge clk);
    cfg_fifo_en = fe; cfg_rdy_ie = rie; cfg_err_ie = eie; cfg_thresh = 4'(th);
    cfg_we = 1'b1;
    @(posedge clk);
    if (fe != m_fifo) q.delete();
    m_fifo = fe; m_rdy = rie; m_err = eie; m_thr = th;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic send(input logic [7:0] b, input bit stop);
    in_flight = 1;
    @(negedge clk);
    rxd = 1'b0;
    repeat (BIT) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = b[i];
      repeat (BIT) @(negedge clk);
    end
    rxd = stop;
    repeat (BIT) @(negedge clk);
    rxd = 1'b1;
    repeat (2 * BIT) @(negedge clk);
    if (q.size() < (m_fifo ? 16 : 1))
      q.push_back({(!stop && b == 8'h00), !stop, b});
    else
      m_ovf = 1;
    in_flight = 0;
  endtask

  task automatic glitch();
    in_flight = 1;
    @(negedge clk);
    rxd = 1'b0;
    repeat (8) @(negedge clk);
    rxd = 1'b1;
    repeat (3 * BIT) @(negedge clk);
    in_flight = 0;
  endtask

  task automatic pop(input logic [7:0] exp, input string tag);
    @(negedge clk);
    chk(rd_valid && rd_data == exp, tag, "head before read", rd_data, exp);
    rd_ready = 1'b1;
    @(posedge clk);
    if (q.size() > 0) void'(q.pop_front());
    @(negedge clk);
    rd_ready = 1'b0;
  endtask

  task automatic clear_ovf();
    @(negedge clk);
    ovf_clr = 1'b1;
    @(posedge clk);
    m_ovf = 0;
    @(negedge clk);
    ovf_clr = 1'b0;
  endtask

  task automatic do_soft_rst();
    @(negedge clk);
    soft_rst = 1'b1;
    @(posedge clk);
    q.delete(); m_fifo = 0; m_rdy = 0; m_err = 0; m_thr = 0; m_ovf = 0;
    @(negedge clk);
    soft_rst = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R13: reset state
    chk(rd_valid == 0, "R13", "rd_valid after reset", rd_valid, 0);
    chk(ovf_flag == 0, "R13", "ovf_flag after reset", ovf_flag, 0);
    chk(irq == 0, "R13", "irq after reset", irq, 0);

    // R6: single-slot mode, second character overflows
    cfg(0, 1, 0, 0);
    send(8'hA5, 1);
    @(negedge clk);
    chk(rd_valid && rd_data == 8'hA5, "R6", "slot holds byte", rd_data, 8'hA5);
    chk(irq == 1, "R9", "irq at one record", irq, 1);
    send(8'h3C, 1);
    @(negedge clk);
    chk(ovf_flag == 1, "R7", "overflow in slot mode", ovf_flag, 1);
    chk(rd_data == 8'hA5, "R6", "slot keeps first byte", rd_data, 8'hA5);
    pop(8'hA5, "R6");
    chk(rd_valid == 0, "R6", "slot empty after read", rd_valid, 0);
    clear_ovf();
    chk(ovf_flag == 0, "R7", "overflow cleared", ovf_flag, 0);

    // R9: threshold of 4 in queue mode
    cfg(1, 1, 0, 3);
    send(8'h11, 1); send(8'h22, 1); send(8'h33, 1);
    @(negedge clk);
    chk(irq == 0, "R9", "irq below threshold", irq, 0);
    send(8'h44, 1);
    @(negedge clk);
    chk(irq == 1, "R9", "irq at threshold", irq, 1);
    // R8: stall holds head
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(rd_valid && rd_data == 8'h11, "R8", "head stable while stalled", rd_data, 8'h11);
    end
    pop(8'h11, "R5"); pop(8'h22, "R5"); pop(8'h33, "R5"); pop(8'h44, "R5");

    // R5/R7: fill 16, one more overflows
    cfg(1, 0, 1, 15);
    for (int i = 0; i < 17; i++) send(8'(i * 13 + 1), 1);
    @(negedge clk);
    chk(ovf_flag == 1, "R7", "overflow at 17th", ovf_flag, 1);
    chk(irq == 1, "R11", "irq from overflow", irq, 1);
    for (int i = 0; i < 16; i++) pop(8'(i * 13 + 1), "R5");
    @(negedge clk);
    chk(rd_valid == 0, "R5", "queue drained", rd_valid, 0);
    clear_ovf();

    // R3/R11: framing error
    send(8'h55, 0);
    @(negedge clk);
    chk(rd_fe == 1 && rd_brk == 0, "R3", "framing flags", {rd_brk, rd_fe}, 2'b01);
    chk(irq == 1, "R11", "irq from framing error", irq, 1);
    cfg(1, 0, 0, 15);
    @(negedge clk);
    chk(irq == 0, "R11", "framing irq disabled", irq, 0);
    pop(8'h55, "R3");

    // R4/R10: break, then a normal frame
    cfg(1, 1, 0, 15);
    send(8'h00, 0);
    @(negedge clk);
    chk(rd_brk == 1 && rd_fe == 1, "R4", "break flags", {rd_brk, rd_fe}, 2'b11);
    chk(irq == 1, "R10", "irq from break", irq, 1);
    cfg(1, 0, 0, 15);
    @(negedge clk);
    chk(irq == 0, "R10", "break irq disabled", irq, 0);
    pop(8'h00, "R4");
    send(8'h5A, 1);
    @(negedge clk);
    chk(rd_valid && rd_fe == 0 && rd_data == 8'h5A, "R3", "recovery after break", rd_data, 8'h5A);
    pop(8'h5A, "R3");

    // R2: glitch is rejected
    glitch();
    @(negedge clk);
    chk(rd_valid == 0, "R2", "glitch stored nothing", rd_valid, 0);
    send(8'hC3, 1);
    pop(8'hC3, "R2");

    // R12: mode change flushes
    send(8'h01, 1); send(8'h02, 1);
    cfg(0, 0, 0, 0);
    @(negedge clk);
    chk(rd_valid == 0, "R12", "flush on mode change", rd_valid, 0);

    // R12: soft reset
    cfg(1, 1, 1, 0);
    send(8'h77, 1);
    @(negedge clk);
    chk(irq == 1, "R12", "irq before soft reset", irq, 1);
    do_soft_rst();
    @(negedge clk);
    chk(rd_valid == 0 && irq == 0 && ovf_flag == 0, "R12", "soft reset clears",
        {rd_valid, irq, ovf_flag}, 0);
    send(8'h81, 1); send(8'h82, 1);
    @(negedge clk);
    chk(ovf_flag == 1 && rd_data == 8'h81, "R12", "single slot after soft reset", rd_data, 8'h81);

    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule